// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32x32 two-colour cursor over a stream of pixels on their way to the display. Each pixel arrives with its x/y screen coordinate and an 8-bit base colour index. The block passes the base index through, or replaces it with one of two overlay colour entries. The output is a 9-bit colour-table entry number: base indices occupy 0..255, and the overlay colours are entry 258 (select bit 0) and entry 259 (select bit 1). A later colour lookup stage resolves these numbers.

The host writes the cursor through a small register window. One word holds the cursor position, with X in the upper half and Y in the lower half. Two 32-row bitmaps follow. The mask plane decides where the cursor is opaque, and the select plane picks which of the two overlay colours is shown. A spare control word reads back with one status bit forced high. Host writes land in shadow copies. The pixel path uses a live copy that loads from the shadows only on a frame-start pulse, so the cursor cannot tear mid-frame. The overlay decision costs one register stage.

Top module: `hwcur_overlay`

## Requirements
- R1: After reset the live and shadow cursor position are both X = 0xF000, Y = 0xF000. Every bitmap row is zero, and the control word is zero, so a read at 0x818 returns 0x02000000.
- R2: A write at offset 0x8FC loads cursor X from data bits 31:16 and cursor Y from data bits 15:0.
- R3: A write at offset 0x900 + 4*r, for r in 0..31, stores mask row r.
- R4: A write at offset 0x980 + 4*r, for r in 0..31, stores select row r.
- R5: A pixel lies in the cursor window when Y <= y <= Y+31 and X <= x <= X+31, with both limits inclusive. Pixels outside the window pass through.
- R6: In a row word, bit 31 belongs to column x = X, and bit 31-k belongs to column x = X+k.
- R7: For a pixel inside the window, a mask bit of 0 outputs the base index zero-extended to 9 bits. A mask bit of 1 outputs 259 when the select bit is 1, and 258 otherwise.
- R8: A pixel with x >= active_width is never overlaid.
- R9: A write at 0x818 stores the control word, and a read there returns it with bit 25 set. Every other offset reads as zero, including the position and bitmap offsets.
- R10: `out_valid` and `out_entry` appear exactly one clock after the matching `pix_valid` cycle.
- R11: Writes to the position and bitmap offsets have no effect on the pixel path until a `frame_start` pulse, which copies all shadows into the live set.
- R12: A cycle with `pix_valid` low produces `out_valid` low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| frame_start | input | 1 | Pulse between frames that loads the live cursor state from the shadows |
| active_width | input | 16 | Visible line width; overlay is clipped at and beyond it |
| pix_valid | input | 1 | Pixel input valid |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel row |
| pix_index | input | 8 | Base colour index |
| out_valid | output | 1 | Output pixel valid |
| out_entry | output | 9 | Colour-table entry number |

## Verification
The embedded assertions assume that every input holds a defined value from the first clock edge. They also assume that `active_width` and the pixel coordinates are stable for the whole cycle in which they are sampled. The stimulus drives every input at time zero. It changes inputs only on the falling edge, and it never pulses `frame_start` in the same cycle as a register write. As a result, the expected live state changes at a single, well-defined point. Coordinates are kept below 0x10000, the window is placed so that its edges and the clip edge can each be hit exactly, and one case leaves the cursor parked at 0xF000 to show that the park position only covers pixels far off any real screen.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

    localparam int CUR_DIM = 32;
    localparam int REG_W   = 32;
    localparam int COORD_W = 16;
    localparam int IDX_W   = 8;
    localparam int ENTRY_W = IDX_W + 1;
    localparam int ADDR_W  = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h818;
    localparam logic [ADDR_W-1:0] OFS_POS  = 12'h8FC;
    localparam int                OFS_MASK = 'h900;
    localparam int                OFS_SEL  = 'h980;

    localparam logic [REG_W-1:0]   CTRL_FORCE = 32'h0200_0000;
    localparam logic [COORD_W-1:0] PARK_POS   = 16'hF000;
    localparam logic [ENTRY_W-1:0] ENT_OVL0   = 9'd258;
    localparam logic [ENTRY_W-1:0] ENT_OVL1   = 9'd259;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } cur_pos_t;

    typedef struct packed {
        logic opaque;   // inside window, unclipped, mask bit set
        logic pick;     // select bit for that pixel
    } cur_tap_t;

    typedef struct packed {
        logic               valid;
        logic [ENTRY_W-1:0] entry;
    } pix_out_t;

    function automatic logic [ENTRY_W-1:0] pick_entry(
        input cur_tap_t tap, input logic [IDX_W-1:0] base);
        if (!tap.opaque)  return {1'b0, base};
        else if (tap.pick) return ENT_OVL1;
        else               return ENT_OVL0;
    endfunction

endpackage

// File: rtl/hwcur_ctrl.sv
module hwcur_ctrl
    import hwcur_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] rdata,
    output cur_pos_t          live_pos
);
    localparam int CW = COORD_W;

    cur_pos_t          shadow_pos;
    logic [DATA_W-1:0] ctrl_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_pos <= '{x: PARK_POS, y: PARK_POS};
            ctrl_word  <= '0;
        end else if (wr_en) begin
            if (addr == OFS_POS) begin
                shadow_pos.x <= wdata[2*CW-1:CW];
                shadow_pos.y <= wdata[CW-1:0];
            end
            if (addr == OFS_CTRL)
                ctrl_word <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            live_pos <= '{x: PARK_POS, y: PARK_POS};
        else if (commit)
            live_pos <= shadow_pos;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL)
            rdata = ctrl_word | CTRL_FORCE;
    end

    // R1
    park_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_pos.x == PARK_POS && live_pos.y == PARK_POS));

    // R9
    ctrl_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_CTRL) |-> rdata[25]);

    // R11
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live_pos));

endmodule

// File: rtl/hwcur_plane.sv
module hwcur_plane
    import hwcur_pkg::*;
#(
    parameter int BASE   = OFS_MASK,
    parameter int DIM    = CUR_DIM,
    parameter int DATA_W = REG_W,
    parameter int AW     = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     commit,
    output logic [DIM-1:0][DIM-1:0]  live
);
    localparam int STRIDE = DATA_W / 8;

    logic [DIM-1:0][DIM-1:0] shadow;

    for (genvar r = 0; r < DIM; r++) begin : g_row
        localparam logic [AW-1:0] ROW_ADDR = AW'(BASE + STRIDE * r);
        always_ff @(posedge clk) begin
            if (rst)
                shadow[r] <= '0;
            else if (wr_en && addr == ROW_ADDR)
                shadow[r] <= wdata[DIM-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            live <= '0;
        else if (commit)
            live <= shadow;
    end

    // R11
    plane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live));

endmodule

// File: rtl/hwcur_hit.sv
module hwcur_hit
    import hwcur_pkg::*;
#(
    parameter int DIM = CUR_DIM,
    parameter int CW  = COORD_W
) (
    input  logic [CW-1:0]            pix_x,
    input  logic [CW-1:0]            pix_y,
    input  logic [CW-1:0]            width,
    input  cur_pos_t                 pos,
    input  logic [DIM-1:0][DIM-1:0]  mask,
    input  logic [DIM-1:0][DIM-1:0]  sel,
    output cur_tap_t                 tap
);
    localparam int OFF_W = $clog2(DIM);

    logic [CW:0]      dx, dy;
    logic             in_x, in_y, in_line;
    logic [OFF_W-1:0] row, col;
    logic [DIM-1:0]   mask_row, sel_row;

    always_comb begin
        dx      = {1'b0, pix_x} - {1'b0, pos.x};
        dy      = {1'b0, pix_y} - {1'b0, pos.y};
        in_x    = !dx[CW] && (dx < (CW+1)'(DIM));
        in_y    = !dy[CW] && (dy < (CW+1)'(DIM));
        in_line = pix_x < width;
        row     = dy[OFF_W-1:0];
        col     = OFF_W'(DIM - 1) - dx[OFF_W-1:0];
        mask_row = mask[row];
        sel_row  = sel[row];
        tap.opaque = in_x && in_y && in_line && mask_row[col];
        tap.pick   = sel_row[col];
    end

endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
    import hwcur_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               frame_start,
    input  logic [COORD_W-1:0] active_width,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [IDX_W-1:0]   pix_index,
    output logic               out_valid,
    output logic [ENTRY_W-1:0] out_entry
);
    cur_pos_t                        live_pos;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] mask_live, sel_live;
    cur_tap_t                        tap;
    pix_out_t                        stage_q;

    hwcur_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .commit(frame_start),
        .rdata(reg_rdata), .live_pos(live_pos)
    );

    hwcur_plane #(.BASE(OFS_MASK)) u_mask (
        .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .commit(frame_start), .live(mask_live)
    );

    hwcur_plane #(.BASE(OFS_SEL)) u_sel (
        .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .commit(frame_start), .live(sel_live)
    );

    hwcur_hit u_hit (
        .pix_x(pix_x), .pix_y(pix_y), .width(active_width),
        .pos(live_pos), .mask(mask_live), .sel(sel_live), .tap(tap)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else begin
            stage_q.valid <= pix_valid;
            stage_q.entry <= pick_entry(tap, pix_index);
        end
    end

    assign out_valid = stage_q.valid;
    assign out_entry = stage_q.entry;

    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(pix_valid)));

    // R8
    clip_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_entry[ENTRY_W-1]) |-> ($past(pix_x) < $past(active_width)));

    // R7
    passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_entry[ENTRY_W-1]) |-> (out_entry[IDX_W-1:0] == $past(pix_index)));

    // R7
    overlay_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_entry[ENTRY_W-1]) |-> (out_entry[IDX_W-1:2] == '0 && out_entry[1]));

endmodule

// File: tb/hwcur_overlay_tb.sv
`timescale 1ns/1ps
module hwcur_overlay_tb;
    import hwcur_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic [15:0] active_width = 16'hFFFF;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic [7:0]  pix_index = '0;
    logic        out_valid;
    logic [8:0]  out_entry;

    always #4 clk = ~clk;

    hwcur_overlay u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .active_width(active_width), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pix_index(pix_index), .out_valid(out_valid),
        .out_entry(out_entry)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    // bench model of the cursor state
    logic [31:0] sh_mask[32], sh_sel[32], lv_mask[32], lv_sel[32];
    int sh_x = 'hF000, sh_y = 'hF000, lv_x = 'hF000, lv_y = 'hF000;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model(input int x, input int y, input int idx);
        int r, b;
        if (y >= lv_y && y < lv_y + 32 && x >= lv_x && x < lv_x + 32 &&
            x < int'(active_width)) begin
            r = y - lv_y;
            b = 31 - (x - lv_x);
            if (lv_mask[r][b]) return lv_sel[r][b] ? 259 : 258;
        end
        return idx;
    endfunction

    task automatic step();
        @(negedge clk);
        reg_we = 0; frame_start = 0; pix_valid = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step();
        reg_we = 1; reg_addr = a[11:0]; reg_wdata = d;
        if (a == 'h8FC) begin sh_x = int'(d[31:16]); sh_y = int'(d[15:0]); end
        if (a >= 'h900 && a < 'h980) sh_mask[(a - 'h900) / 4] = d;
        if (a >= 'h980 && a < 'hA00) sh_sel[(a - 'h980) / 4] = d;
    endtask

    task automatic commit();
        step();
        frame_start = 1;
        lv_x = sh_x; lv_y = sh_y;
        for (int i = 0; i < 32; i++) begin
            lv_mask[i] = sh_mask[i]; lv_sel[i] = sh_sel[i];
        end
    endtask

    task automatic pix(input int x, input int y, input int idx, input string tag);
        step();
        pix_valid = 1; pix_x = x[15:0]; pix_y = y[15:0]; pix_index = idx[7:0];
        exp_q.push_back(model(x, y, idx));
        tag_q.push_back(tag);
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        step();
        reg_addr = a[11:0];
        #1;
        check(reg_rdata == exp, tag, int'(reg_rdata), exp);
    endtask

    // monitor: compares each produced pixel with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (out_valid) begin
                if (exp_q.size() == 0)
                    check(0, "R10 unexpected output", int'(out_entry), -1);
                else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_entry) == e, t, int'(out_entry), e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            sh_mask[i] = 0; sh_sel[i] = 0; lv_mask[i] = 0; lv_sel[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd('h818, 'h0200_0000, "R1 control reset read");
        step(); #2;
        check(out_valid == 0, "R1 no output after reset", int'(out_valid), 0);

        // R3 R4: fill bitmaps, position still parked
        for (int r = 0; r < 32; r++) wr('h900 + 4*r, 32'hFFFF_FFFF);
        for (int r = 0; r < 32; r++) wr('h980 + 4*r, 32'h0000_FFFF);
        commit();
        active_width = 16'hFFFF;
        pix(0, 0, 7, "R1 parked cursor origin");
        pix(40, 20, 9, "R1 parked cursor screen");
        pix('hF000, 'hF000, 3, "R1 R6 park corner select 0");
        pix('hF010, 'hF01F, 4, "R4 R6 park column 16 select 1");

        // R11: position write before commit has no effect
        wr('h8FC, 32'h0064_0032);
        pix(100, 50, 'h11, "R11 uncommitted position");
        wr('h900, 32'h8000_0001);
        wr('h900 + 4*31, 32'h8000_0001);
        wr('h980, 32'h8000_0000);
        wr('h980 + 4*31, 32'h0000_0001);
        wr('h900 + 4*5, 32'hFFFF_FFFF);
        wr('h980 + 4*5, 32'h0000_FFFF);
        commit();

        // R2 R5 R6 R7 window edges
        active_width = 200;
        pix(100, 50, 1, "R6 leftmost bit 31 select 1");
        pix(101, 50, 2, "R7 mask 0 passthrough");
        pix(131, 50, 3, "R5 right edge select 0");
        pix(99, 50, 4, "R5 left of window");
        pix(132, 50, 5, "R5 right of window");
        pix(100, 49, 6, "R5 above window");
        pix(100, 81, 7, "R5 bottom row select 0");
        pix(131, 81, 8, "R5 bottom right select 1");
        pix(100, 82, 9, "R5 below window");

        // R8 clipping
        active_width = 120;
        pix(119, 55, 10, "R8 last visible column");
        pix(120, 55, 11, "R8 clipped at width");
        pix(125, 55, 12, "R8 clipped beyond width");

        // R12 / R10
        step(); step(); #2;
        check(out_valid == 0, "R12 idle cycle gives no output", int'(out_valid), 0);

        // R2 field order
        wr('h8FC, 32'h0005_0000);
        commit();
        pix(5, 0, 13, "R2 X from upper half");
        pix(0, 5, 14, "R2 Y from lower half");

        // R9 readback
        wr('h818, 32'h0000_0ABC);
        rd('h818, 'h0200_0ABC, "R9 control readback");
        rd('h8FC, 0, "R9 position reads zero");
        rd('h900, 0, "R9 mask reads zero");
        rd('h81C, 0, "R9 other offset reads zero");

        repeat (4) step();
        check(exp_q.size() == 0, "R10 all outputs delivered", exp_q.size(), 0);
        done = 1;
        finish_run();
    end

endmodule